// File: doc/BRIEF.md
# Integer Add/Subtract Instruction Executor

This block takes in at most one 32-bit instruction word per clock, qualified by a valid strobe. It runs that word against a private bank of thirty-two 32-bit registers. Three encodings are recognised:

- a register-to-register add;
- a register-to-register subtract;
- an add of a sign-extended 16-bit constant.

The result is written back at the clock edge that accepts the word. Register zero is fixed at zero. A program counter moves forward by four for each accepted word.

Any other opcode or function code in a valid word raises an illegal flag during that cycle and leaves the register bank unchanged. A combinational inspection port returns the contents of any register, so a test environment can watch results without stopping the flow of instructions.

Top module: `int_exec_core`

## Requirements
- R1: While reset is held, and after it is released, the program counter reads 0, the illegal flag is 0, and every register reads 0.
- R2: A word with opcode bits [31:26] = 0 and function bits [5:0] = 32 writes reg[bits 25:21] + reg[bits 20:16] into reg[bits 15:11]. Word 0x012A4020 adds register 9 and register 10 into register 8.
- R3: A word with opcode 0 and function 34 writes reg[bits 25:21] − reg[bits 20:16] into reg[bits 15:11].
- R4: A word with opcode 8 writes reg[bits 25:21] plus bits [15:0] into reg[bits 20:16]. Bits [15:0] are sign-extended to 32 bits before the add. Word 0x2008000A loads 10 into register 8.
- R5: Register 0 always reads as zero, both as an operand and on the inspection port. Writes that target it have no effect.
- R6: Sums and differences wrap modulo 2^32, and the illegal flag stays low for them.
- R7: The program counter grows by 4 on each clock edge where valid is high, and holds its value otherwise.
- R8: A valid word whose opcode/function pair is none of the three above drives the illegal flag high in the same cycle, before the edge. It changes no register, and the program counter still advances.
- R9: Bits [10:6] of a register-format word have no influence on the result.
- R10: The inspection port shows the selected register combinationally. A write becomes visible on it right after the accepting edge, and an operand read in the same cycle sees the old value.
- R11: While valid is low, the instruction word is ignored: no register changes, the program counter holds, and the illegal flag stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_valid | input | 1 | Instruction word is presented this cycle |
| instr_word | input | 32 | Instruction word |
| dbg_sel | input | 5 | Register index for the inspection port |
| dbg_data | output | 32 | Contents of the selected register |
| pc | output | 32 | Program counter |
| illegal | output | 1 | Valid word has an unsupported encoding |

## Verification
The bench feeds the two fixed words given in the requirements, then exercises the subtract and the constant add. Negative constants would come out as large positives in a design that zero-extends. Differences below zero and sums past 2^32 would raise a spurious flag in a design that traps overflow. Writes aimed at register 0 would later leak into sums if the zero register were writable. A destination that is also a source would show a doubled effect if the operand read took the new value. Shift-amount bits that leak into decode would change results, and so would any use of a word presented with valid low. The illegal cases check that the flag rises, that no register changes, and that the program counter still moves.

// File: rtl/iexe_pkg.sv
package iexe_pkg;
  localparam int unsigned IW = 32;
  localparam logic [5:0] OPC_REG  = 6'd0;
  localparam logic [5:0] OPC_ADDI = 6'd8;
  localparam logic [5:0] FN_ADD   = 6'd32;
  localparam logic [5:0] FN_SUB   = 6'd34;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_ADD  = 2'd1,
    K_SUB  = 2'd2,
    K_ADDI = 2'd3
  } op_kind_e;
endpackage

// File: rtl/iexe_decode.sv
module iexe_decode
  import iexe_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned AW   = 5
) (
  input  logic               valid,
  input  logic [IW-1:0]      word,
  output logic [AW-1:0]      src_a,
  output logic [AW-1:0]      src_b,
  output logic [AW-1:0]      dst,
  output logic               wr_en,
  output logic               use_imm,
  output logic               do_sub,
  output logic [XLEN-1:0]    imm_ext,
  output logic               illegal
);
  logic [5:0]  opc;
  logic [5:0]  fn;
  logic [15:0] imm;
  op_kind_e    kind;

  assign opc   = word[31:26];
  assign fn    = word[5:0];
  assign imm   = word[15:0];
  assign src_a = word[21 +: AW];
  assign src_b = word[16 +: AW];

  always_comb begin
    kind = K_NONE;
    if (opc == OPC_REG) begin
      if (fn == FN_ADD)      kind = K_ADD;
      else if (fn == FN_SUB) kind = K_SUB;
    end else if (opc == OPC_ADDI) begin
      kind = K_ADDI;
    end
  end

  assign use_imm = (kind == K_ADDI);
  assign do_sub  = (kind == K_SUB);
  assign dst     = use_imm ? word[16 +: AW] : word[11 +: AW];
  assign wr_en   = valid && (kind != K_NONE);
  assign illegal = valid && (kind == K_NONE);
  assign imm_ext = {{(XLEN-16){imm[15]}}, imm};
endmodule

// File: rtl/iexe_alu.sv
module iexe_alu #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic            do_sub,
  output logic [XLEN-1:0] result
);
  logic [XLEN-1:0] b_eff;
  assign b_eff  = do_sub ? ~op_b : op_b;
  assign result = op_a + b_eff + {{(XLEN-1){1'b0}}, do_sub};
endmodule

// File: rtl/iexe_regfile.sv
module iexe_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic [AW-1:0]   ra_addr,
  output logic [XLEN-1:0] ra_data,
  input  logic [AW-1:0]   rb_addr,
  output logic [XLEN-1:0] rb_data,
  input  logic [AW-1:0]   dbg_addr,
  output logic [XLEN-1:0] dbg_data
);
  logic [NREG-1:0][XLEN-1:0] bank;

  assign bank[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_entry
    logic            en;
    logic [XLEN-1:0] q;
    assign en = wr_en && (wr_addr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wr_data;
    end
    assign bank[i] = q;
  end

  assign ra_data  = bank[ra_addr];
  assign rb_data  = bank[rb_addr];
  assign dbg_data = bank[dbg_addr];
endmodule

// File: rtl/int_exec_core.sv
module int_exec_core
  import iexe_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned NREG    = 32,
  parameter int unsigned PC_STEP = 4,
  localparam int unsigned AW     = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [IW-1:0]   instr_word,
  input  logic [AW-1:0]   dbg_sel,
  output logic [XLEN-1:0] dbg_data,
  output logic [XLEN-1:0] pc,
  output logic            illegal
);
  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  logic [AW-1:0]   src_a, src_b, dst;
  logic            wr_en, use_imm, do_sub;
  logic [XLEN-1:0] imm_ext, a_val, b_reg, b_val, result;
  logic [XLEN-1:0] pc_d, pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  iexe_decode #(.XLEN(XLEN), .AW(AW)) u_dec (
    .valid   (instr_valid),
    .word    (instr_word),
    .src_a   (src_a),
    .src_b   (src_b),
    .dst     (dst),
    .wr_en   (wr_en),
    .use_imm (use_imm),
    .do_sub  (do_sub),
    .imm_ext (imm_ext),
    .illegal (illegal)
  );

  iexe_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_addr  (dst),
    .wr_data  (result),
    .ra_addr  (src_a),
    .ra_data  (a_val),
    .rb_addr  (src_b),
    .rb_data  (b_reg),
    .dbg_addr (dbg_sel),
    .dbg_data (dbg_data)
  );

  assign b_val = use_imm ? imm_ext : b_reg;

  iexe_alu #(.XLEN(XLEN)) u_alu (
    .op_a   (a_val),
    .op_b   (b_val),
    .do_sub (do_sub),
    .result (result)
  );

  always_comb begin
    pc_d = pc_q;
    if (instr_valid) pc_d = pc_q + XLEN'(PC_STEP);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pc_q <= '0;
    else             pc_q <= pc_d;
  end

  assign pc = pc_q;
endmodule

// File: rtl/iexe_checker.sv
module iexe_checker #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned AW      = 5,
  parameter int unsigned PC_STEP = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instr_valid,
  input logic            illegal,
  input logic            wr_en,
  input logic [AW-1:0]   dbg_sel,
  input logic [XLEN-1:0] dbg_data,
  input logic [XLEN-1:0] pc
);
  a_r7_pc_advance: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |=> pc == $past(pc) + XLEN'(PC_STEP));

  a_r7_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> $stable(pc));

  a_r8_flag_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> instr_valid);

  a_r8_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wr_en);

  a_r5_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_sel == '0 |-> dbg_data == '0);

  a_r11_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> (!$stable(dbg_sel) || $stable(dbg_data)));
endmodule

bind int_exec_core iexe_checker #(.XLEN(XLEN), .AW(AW), .PC_STEP(PC_STEP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .instr_valid (instr_valid),
  .illegal     (illegal),
  .wr_en       (wr_en),
  .dbg_sel     (dbg_sel),
  .dbg_data    (dbg_data),
  .pc          (pc)
);

// File: tb/int_exec_core_bench.sv
module int_exec_core_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic [31:0] instr_word;
  logic [4:0]  dbg_sel;
  logic [31:0] dbg_data, pc;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] exp_reg [32];
  logic [31:0] exp_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_exec_core u_int_exec_core (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .dbg_sel(dbg_sel), .dbg_data(dbg_data), .pc(pc), .illegal(illegal)
  );

  function automatic logic [31:0] rw(input int rs, input int rt, input int rd,
                                     input int sh, input int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction

  function automatic logic [31:0] iw(input int op, input int rs, input int rt,
                                     input logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_reg(input int idx, input string tag);
    dbg_sel = 5'(idx);
    #1;
    check($sformatf("%s reg%0d", tag, idx), dbg_data, exp_reg[idx]);
  endtask

  // Spec model: R2, R3, R4, R5, R8
  task automatic run(input logic [31:0] w, input string tag);
    logic [5:0] op;
    logic [5:0] fn;
    int rs, rt, dst;
    bit legal;
    logic [31:0] val;
    op = w[31:26]; fn = w[5:0];
    rs = int'(w[25:21]); rt = int'(w[20:16]);
    legal = 1; dst = 0; val = '0;
    if (op == 6'd0 && fn == 6'd32) begin
      dst = int'(w[15:11]); val = exp_reg[rs] + exp_reg[rt];
    end else if (op == 6'd0 && fn == 6'd34) begin
      dst = int'(w[15:11]); val = exp_reg[rs] - exp_reg[rt];
    end else if (op == 6'd8) begin
      dst = rt; val = exp_reg[rs] + {{16{w[15]}}, w[15:0]};
    end else legal = 0;
    @(negedge clk);
    instr_valid = 1'b1;
    instr_word  = w;
    #1;
    check({tag, " illegal flag"}, {31'd0, illegal}, {31'd0, !legal});
    @(posedge clk);
    #1;
    instr_valid = 1'b0;
    if (legal && dst != 0) exp_reg[dst] = val;
    exp_pc = exp_pc + 32'd4;
    check({tag, " pc R7"}, pc, exp_pc);
  endtask

  task automatic t_reset;
    check("R1 pc", pc, 32'd0);
    check("R1 illegal", {31'd0, illegal}, 32'd0);
    for (int i = 0; i < 32; i++) check_reg(i, "R1");
  endtask

  task automatic t_known_words;
    run(32'h2008000A, "R4 known addi");
    check_reg(8, "R4 known addi");
    run(iw(8, 0, 9, 16'd100), "R4 set r9");
    run(iw(8, 0, 10, 16'd23), "R4 set r10");
    run(32'h012A4020, "R2 known add");
    check_reg(8, "R2 known add");
    check("R2 r8 is 123", dbg_data, 32'd123);
  endtask

  task automatic t_sub_and_imm;
    run(rw(9, 10, 12, 0, 34), "R3 sub");
    check_reg(12, "R3 sub");
    run(rw(10, 9, 13, 0, 34), "R3 sub negative");
    check_reg(13, "R3 sub negative");
    run(iw(8, 0, 6, 16'hFFFF), "R4 neg imm");
    check_reg(6, "R4 neg imm");
    run(iw(8, 6, 6, 16'h8000), "R4 most negative imm");
    check_reg(6, "R4 most negative imm");
    check("R4 r6 value", dbg_data, 32'hFFFF7FFF);
  endtask

  task automatic t_zero_reg;
    run(iw(8, 0, 0, 16'd5), "R5 addi to r0");
    check_reg(0, "R5 addi to r0");
    run(rw(9, 10, 0, 0, 32), "R5 add to r0");
    check_reg(0, "R5 add to r0");
    run(iw(8, 0, 7, 16'd3), "R5 set r7");
    run(rw(0, 0, 7, 0, 32), "R5 r0 operand");
    check_reg(7, "R5 r0 operand");
    check("R5 r7 zero", dbg_data, 32'd0);
  endtask

  task automatic t_wrap;
    run(iw(8, 0, 1, 16'd1), "R6 set r1");
    run(rw(0, 1, 2, 0, 34), "R6 underflow");
    check_reg(2, "R6 underflow");
    check("R6 r2 all ones", dbg_data, 32'hFFFFFFFF);
    run(rw(2, 1, 3, 0, 32), "R6 overflow");
    check_reg(3, "R6 overflow");
    run(iw(8, 2, 4, 16'd2), "R6 addi wrap");
    check_reg(4, "R6 addi wrap");
  endtask

  task automatic t_shamt_and_alias;
    run(rw(9, 10, 11, 31, 32), "R9 shamt add");
    check_reg(11, "R9 shamt add");
    run(rw(9, 10, 14, 17, 34), "R9 shamt sub");
    check_reg(14, "R9 shamt sub");
    run(rw(9, 9, 9, 0, 32), "R10 same reg");
    check_reg(9, "R10 same reg");
    check("R10 r9 doubled once", dbg_data, 32'd200);
  endtask

  task automatic t_illegal;
    run(rw(9, 10, 15, 0, 33), "R8 funct 33");
    check_reg(15, "R8 funct 33");
    run(iw(9, 9, 16, 16'd1), "R8 opcode 9");
    check_reg(16, "R8 opcode 9");
    run(32'hFFFFFFFF, "R8 all ones");
    check_reg(31, "R8 all ones");
    run(iw(35, 9, 9, 16'd4), "R8 opcode 35");
    check_reg(9, "R8 opcode 35");
  endtask

  task automatic t_idle;
    @(negedge clk);
    instr_valid = 1'b0;
    instr_word  = iw(8, 0, 17, 16'd77);
    #1;
    check("R11 idle illegal", {31'd0, illegal}, 32'd0);
    @(posedge clk);
    #1;
    check("R11 idle pc", pc, exp_pc);
    check_reg(17, "R11 idle");
    @(negedge clk);
    instr_word = 32'hFFFFFFFF;
    #1;
    check("R11 idle bad word flag", {31'd0, illegal}, 32'd0);
    @(posedge clk);
    #1;
    check("R11 idle pc hold", pc, exp_pc);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    instr_valid = 1'b0;
    instr_word = '0;
    dbg_sel = '0;
    exp_pc = '0;
    for (int i = 0; i < 32; i++) exp_reg[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 pc in reset", pc, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_known_words();
    t_sub_and_imm();
    t_zero_reg();
    t_wrap();
    t_shamt_and_alias();
    t_illegal();
    t_idle();
    for (int i = 0; i < 32; i++) check_reg(i, "R10 final sweep");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule